// File: doc/BRIEF.md
# Persistent-Change Wake Detector

This block raises a wake request from a single wake pad while the device sits in its power-off state. It runs on a slow always-on clock. When the device enters power-off, the block takes a snapshot of the synchronised pad level as its reference. From then on it counts consecutive slow-clock cycles in which the pad differs from that reference. If the pad comes back to the reference level, the count drops straight to zero. As a result, only a level change that persists for the configured number of cycles sets the sticky wake flag. That flag is meant to restart the power manager and its low-frequency oscillator.

A saturating counter on the slow clock stands in for an analog charge-and-threshold integrator. A set/reset latch holds the wake flag. In that latch a clear command always beats a set command. Every command input is active-high, so an undriven (zero) command input leaves the detector idle.

Top module: `pwd_wake_det`

## Requirements
- R1: After reset, `wake_o` is 0 and the detector is unarmed.
- R2: While unarmed, pad activity of any kind leaves `wake_o` at 0.
- R3: A one-cycle pulse on `sleep_enter_i` stores the synchronised pad level as the reference, clears the count and arms the detector.
- R4: The pad must differ from the reference for `THRESH` consecutive slow-clock cycles (default 10). If the new pad level is first sampled at edge a, `wake_o` goes to 1 after edge a+`THRESH`+2. This delay includes the two synchroniser stages.
- R5: A differing run shorter than `THRESH` cycles leaves `wake_o` at 0. A single cycle back at the reference level discards all earlier progress, so two short runs never add up.
- R6: Once set, `wake_o` stays at 1 after the pad returns to the reference level.
- R7: `wake_clr_i`, or a new `sleep_enter_i`, drives `wake_o` to 0 after the next edge.
- R8: `wake_set_i` drives `wake_o` to 1 after the next edge.
- R9: When a clear command (`wake_clr_i` or `sleep_enter_i`) and a set condition fall in the same cycle, the clear wins and `wake_o` is 0 after that edge.
- R10: The count saturates at 2^`CNT_W`-1 and does not wrap. While the pad keeps differing past the threshold, a clear removes `wake_o` for exactly one cycle, and `wake_o` returns at the following edge.
- R11: With all command inputs held at 0, `wake_o` never changes unless the pad is involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_i | input | 1 | Asynchronous wake pad level |
| sleep_enter_i | input | 1 | Power-off entry pulse: capture reference, arm, clear |
| wake_set_i | input | 1 | Force the wake flag to 1 |
| wake_clr_i | input | 1 | Clear the wake flag |
| wake_o | output | 1 | Sticky wake request |

## Verification
Two functions can land in the same cycle: the integrator reaching the threshold, and a clear command. The bench provokes this by holding the pad away from the reference for exactly `THRESH` cycles, so the set condition lasts for one cycle only. It pulses `wake_clr_i` in precisely that cycle and expects `wake_o` to stay 0 from then on. The same collision is also driven with `wake_set_i` and with a saturated counter. In the saturated case the flag must drop for one cycle and come back at the next edge.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
    typedef enum logic [1:0] {
        LATCH_HOLD = 2'd0,
        LATCH_SET  = 2'd1,
        LATCH_CLR  = 2'd2
    } latch_op_t;
endpackage

// File: rtl/pwd_sync.sv
module pwd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = async_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pwd_integrator.sv
module pwd_integrator #(
    parameter int CNT_W  = 4,
    parameter int THRESH = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad_s_i,
    input  logic arm_i,
    output logic reach_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] THR     = CNT_W'(THRESH);

    typedef struct packed {
        logic             ref_lvl;
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } integ_t;

    integ_t st_d, st_q;
    logic   differ;

    always_comb begin
        st_d   = st_q;
        differ = st_q.armed & (pad_s_i ^ st_q.ref_lvl);
        if (arm_i) begin
            st_d.ref_lvl = pad_s_i;
            st_d.armed   = 1'b1;
            st_d.cnt     = '0;
        end else if (differ) begin
            if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reach_o = st_q.armed && (st_q.cnt >= THR);

    // R3
    ref_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> (st_q.armed && st_q.cnt == '0 && st_q.ref_lvl == $past(pad_s_i)));

    // R5
    discharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_i && st_q.armed && pad_s_i == st_q.ref_lvl) |=> st_q.cnt == '0);

    // R10
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_i && st_q.armed && pad_s_i != st_q.ref_lvl && st_q.cnt == CNT_MAX)
            |=> st_q.cnt == CNT_MAX);

    // R2
    unarmed_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.armed && !arm_i) |=> st_q.cnt == '0);
endmodule

// File: rtl/pwd_wake_latch.sv
module pwd_wake_latch
    import pwd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic      wake_d, wake_q;
    latch_op_t op;

    always_comb begin
        if (clr_i)      op = LATCH_CLR;
        else if (set_i) op = LATCH_SET;
        else            op = LATCH_HOLD;
        case (op)
            LATCH_SET: wake_d = 1'b1;
            LATCH_CLR: wake_d = 1'b0;
            default:   wake_d = wake_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wake_q <= 1'b0;
        else        wake_q <= wake_d;
    end

    assign q_o = wake_q;

    // R9
    clr_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !q_o);

    // R8
    set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> q_o);

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/pwd_wake_det.sv
module pwd_wake_det #(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 4,
    parameter int THRESH      = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad_i,
    input  logic sleep_enter_i,
    input  logic wake_set_i,
    input  logic wake_clr_i,
    output logic wake_o
);
    logic pad_s, reach, set_req, clr_req;

    pwd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pad_i), .sync_o(pad_s)
    );

    pwd_integrator #(.CNT_W(CNT_W), .THRESH(THRESH)) u_integ (
        .clk(clk), .rst_n(rst_n), .pad_s_i(pad_s), .arm_i(sleep_enter_i),
        .reach_o(reach)
    );

    assign set_req = reach | wake_set_i;
    assign clr_req = wake_clr_i | sleep_enter_i;

    pwd_wake_latch u_latch (
        .clk(clk), .rst_n(rst_n), .set_i(set_req), .clr_i(clr_req), .q_o(wake_o)
    );

    // R7
    sleep_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_enter_i |=> !wake_o);

    // R11
    idle_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_enter_i && !wake_set_i && !wake_clr_i && !reach) |=> $stable(wake_o));
endmodule

// File: tb/pwd_wake_det_tb.sv
`timescale 1ns/1ps
module pwd_wake_det_tb;
    localparam int T = 10;
    localparam int W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pad = 1'b0, slp = 1'b0, wset = 1'b0, wclr = 1'b0;
    logic wake;
    int   n_chk = 0, n_bad = 0;
    bit   done = 0;

    always #2.5 clk = ~clk;

    pwd_wake_det #(.SYNC_STAGES(2), .CNT_W(W), .THRESH(T)) u_dut (
        .clk(clk), .rst_n(rst_n), .pad_i(pad), .sleep_enter_i(slp),
        .wake_set_i(wset), .wake_clr_i(wclr), .wake_o(wake)
    );

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: wake_o=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic enter_sleep(logic lvl);
        pad = lvl;
        wait_n(3);
        slp = 1'b1;
        wait_n(1);
        slp = 1'b0;
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            report();
        end
    end

    initial begin
        wait_n(3);
        chk("R1 reset", wake, 1'b0);
        rst_n = 1'b1;
        wait_n(2);
        chk("R1 after release", wake, 1'b0);

        // R2: unarmed, pad toggles and then holds high
        for (int i = 0; i < 30; i++) begin pad = ~pad; wait_n(1); end
        pad = 1'b1; wait_n(30);
        chk("R2 unarmed toggles", wake, 1'b0);
        // R11: idle command inputs, nothing changes
        pad = 1'b0; wait_n(20);
        chk("R11 idle inputs", wake, 1'b0);

        // R3 R4 R5 R6: sweep the run length for both reference levels
        for (int rv = 0; rv < 2; rv++) begin
            for (int len = 1; len <= T + 3; len++) begin
                enter_sleep(rv[0]);
                chk("R3 armed clear", wake, 1'b0);
                pad = ~rv[0];
                for (int m = 1; m <= len; m++) begin
                    wait_n(1);
                    if (m == T + 2) chk("R4 not before edge a+T+2", wake, 1'b0);
                    if (m == T + 3) chk("R4 rise at edge a+T+2", wake, 1'b1);
                end
                pad = rv[0];
                wait_n(T + 6);
                if (len >= T) chk("R6 sticky after return", wake, 1'b1);
                else          chk("R5 short run ignored", wake, 1'b0);
            end
        end

        // R5: two short runs split by one reference cycle
        enter_sleep(1'b1);
        pad = 1'b0; wait_n(T - 1);
        pad = 1'b1; wait_n(1);
        pad = 1'b0; wait_n(T - 1);
        pad = 1'b1; wait_n(T + 6);
        chk("R5 progress discarded", wake, 1'b0);

        // R9: clear lands in the single set cycle
        enter_sleep(1'b0);
        pad = 1'b1; wait_n(T);
        pad = 1'b0; wait_n(2);
        wclr = 1'b1; wait_n(1); wclr = 1'b0;
        chk("R9 clear beats threshold", wake, 1'b0);
        wait_n(5);
        chk("R9 stays clear", wake, 1'b0);

        // R9 with the explicit set, then R8 and R7
        wset = 1'b1; wclr = 1'b1; wait_n(1); wset = 1'b0; wclr = 1'b0;
        chk("R9 clear beats set", wake, 1'b0);
        wset = 1'b1; wait_n(1); wset = 1'b0;
        chk("R8 explicit set", wake, 1'b1);
        wait_n(4);
        chk("R6 set holds", wake, 1'b1);
        wclr = 1'b1; wait_n(1); wclr = 1'b0;
        chk("R7 explicit clear", wake, 1'b0);

        // R7 and R3: a new sleep entry clears and re-references
        enter_sleep(1'b0);
        pad = 1'b1; wait_n(T + 4);
        chk("R4 wake before re-entry", wake, 1'b1);
        enter_sleep(1'b1);
        chk("R7 sleep entry clears", wake, 1'b0);
        wait_n(T + 10);
        chk("R3 new reference holds", wake, 1'b0);

        // R10: saturated counter, clear mid-persistence
        enter_sleep(1'b0);
        pad = 1'b1; wait_n(40);
        chk("R10 long run woke", wake, 1'b1);
        wclr = 1'b1; wait_n(1); wclr = 1'b0;
        chk("R10 clear for one cycle", wake, 1'b0);
        wait_n(1);
        chk("R10 reasserts next edge", wake, 1'b1);
        pad = 1'b0; wait_n(5);
        chk("R6 held after return", wake, 1'b1);

        done = 1;
        report();
    end
endmodule